// File: doc/BRIEF.md
# Saturating Vector Element ALU

This block handles one vector element per clock. It takes two integer operands and one of four operations: add, subtract, multiply, or add with a carry-out. It works at a chosen element width and can clamp the result into the range of the destination width. A separate select bit decides whether the operands and the clamp range are treated as unsigned or as signed.

The block can also produce a 4-bit condition field for each element. The field holds less-than, greater-than and equal, each found by comparing the final result with zero. Its fourth bit records whether this element was saturated; for the carry operation it holds the carry-out instead. The block keeps no flag that carries over from one element to the next. So a long run of elements can go through it, and any later stage can read each element's condition field on its own.

Some input combinations are illegal: saturation requested on the carry operation, or a reserved width code. The block reports these with a one-cycle flag and does not update its result or condition outputs.

Top module: `sat_elem_alu`

## Requirements
- R1: After reset is asserted (rst_n low at a clock edge), out_valid, illegal, result and cond are all zero.
- R2: Each input accepted while in_valid is high produces out_valid or illegal exactly one clock later. With in_valid low, both are low on the next cycle, and result and cond hold their values.
- R3: With sgn_n=0 and sat_en=1, the result is clamped to the unsigned destination range, from 0 to 2^width-1. Width codes are 0=8, 1=16 and 2=32 bits.
- R4: With sgn_n=1 and sat_en=1, the result is clamped to the signed destination range, from -2^(width-1) to 2^(width-1)-1.
- R5: Both operands are taken from the low source-width bits and are sign-extended (sgn_n=1) or zero-extended (sgn_n=0). The operation is then computed exactly, at no less than the larger of the two widths, before the destination clamp is applied.
- R6: With sat_en=0, the result is the low destination-width bits of the exact result (wraparound).
- R7: The cond field is laid out as bit3=lt, bit2=gt, bit1=eq. These bits compare the final destination-width result with zero, signed when sgn_n=1 and unsigned otherwise. Exactly one of the three is set.
- R8: cond bit0 is 1 exactly when this element saturated. No state carries over from earlier elements.
- R9: For op_sel code 3 (add with carry), the result wraps, and cond bit0 holds the carry-out of the destination-width unsigned add. The other op_sel codes are 0=add, 1=subtract and 2=multiply.
- R10: Any of the following is illegal: sat_en=1 with op_sel=3, or a width code of 3 on either src_w or dst_w. On the next cycle an illegal input gives illegal=1 and out_valid=0, and result and cond keep their previous values.
- R11: With cond_en=0, cond is 4'b0000.
- R12: The result bits above the destination width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Element present on the inputs |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| src_w | input | 2 | Source width code (0=8, 1=16, 2=32, 3 reserved) |
| dst_w | input | 2 | Destination width code (0=8, 1=16, 2=32, 3 reserved) |
| op_sel | input | 2 | Operation: 0 add, 1 sub, 2 mul, 3 add with carry |
| sgn_n | input | 1 | 1 selects signed operation and signed clamp |
| sat_en | input | 1 | Enable saturation |
| cond_en | input | 1 | Enable the condition field |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Clamped or wrapped result, zero above the destination width |
| cond | output | 4 | {lt, gt, eq, sat-or-carry} |
| illegal | output | 1 | Previous input was an illegal combination |

## Verification
Every result, condition field and strobe is due one clock edge after the input is presented. The bench drives each input on a falling edge and samples the outputs on the next falling edge, which comes half a period after the single register stage has updated. For an illegal input, the same sampling point confirms two things: result and cond still match the values from the last legal element, and out_valid is low. An idle cycle is sampled in the same way to confirm that the strobes drop while the data holds.

// File: rtl/sat_elem_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the saturating element ALU.
// Assumes width codes select MIN_W << code, with code 3 reserved.
package sat_elem_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_ADDC = 2'd3
    } op_e;

    localparam logic [1:0] W_RESERVED = 2'd3;

    // Number of bits named by a width code; the reserved code maps to max_w.
    function automatic int unsigned lane_bits(input logic [1:0] code,
                                              input int unsigned min_w,
                                              input int unsigned max_w);
        if (code == W_RESERVED) begin
            return max_w;
        end
        return min_w << code;
    endfunction

endpackage

// File: rtl/sat_elem_ext.sv
`timescale 1ns/1ps
// Operand extender: keeps the low lane bits of a raw operand and sign- or
// zero-extends them into the wide exact-arithmetic domain.
// Assumes lane_w is between 1 and DATA_W.
module sat_elem_ext #(
    parameter int DATA_W = 32,
    parameter int WIDE_W = 2 * DATA_W + 2,
    parameter int BW     = 8
) (
    input  logic [DATA_W-1:0]        raw,
    input  logic [BW-1:0]            lane_w,
    input  logic                     sgn,
    output logic signed [WIDE_W-1:0] wide
);

    localparam logic [WIDE_W-1:0] ONE = {{(WIDE_W-1){1'b0}}, 1'b1};

    logic [WIDE_W-1:0] lane_mask;
    logic [WIDE_W-1:0] raw_wide;
    logic [BW-1:0]     top_idx;
    logic              top_bit;

    // Build the lane mask and select the lane's top bit.
    always_comb begin
        lane_mask = (ONE << lane_w) - ONE;
        raw_wide  = {{(WIDE_W-DATA_W){1'b0}}, raw};
        top_idx   = lane_w - BW'(1);
        top_bit   = raw_wide[top_idx];
    end

    // Extend the lane into the wide domain according to signedness.
    always_comb begin
        if (sgn && top_bit) begin
            wide = signed'((raw_wide & lane_mask) | ~lane_mask);
        end else begin
            wide = signed'(raw_wide & lane_mask);
        end
    end

endmodule

// File: rtl/sat_elem_arith.sv
`timescale 1ns/1ps
// Exact arithmetic: computes add, subtract or multiply without loss in a
// domain twice the data width plus guard bits, and the destination-width
// carry-out for the carry-producing add.
// Assumes operands are already extended from their source width.
module sat_elem_arith
    import sat_elem_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIDE_W = 2 * DATA_W + 2,
    parameter int BW     = 8
) (
    input  logic signed [WIDE_W-1:0] opa,
    input  logic signed [WIDE_W-1:0] opb,
    input  op_e                      op,
    input  logic [BW-1:0]            dst_bits,
    output logic signed [WIDE_W-1:0] exact,
    output logic                     carry
);

    localparam logic [WIDE_W-1:0] ONE = {{(WIDE_W-1){1'b0}}, 1'b1};

    logic [WIDE_W-1:0] dmask;
    logic [WIDE_W-1:0] lane_sum;

    // Select the exact result of the requested operation.
    always_comb begin
        unique case (op)
            OP_SUB:  exact = opa - opb;
            OP_MUL:  exact = opa * opb;
            default: exact = opa + opb;
        endcase
    end

    // Carry-out of the unsigned add of the destination-width lanes.
    always_comb begin
        dmask    = (ONE << dst_bits) - ONE;
        lane_sum = (unsigned'(opa) & dmask) + (unsigned'(opb) & dmask);
        carry    = lane_sum[dst_bits];
    end

endmodule

// File: rtl/sat_elem_clamp.sv
`timescale 1ns/1ps
// Destination clamp: saturates the exact result to the unsigned or signed
// destination range, or wraps it when saturation is off, and reports
// whether a saturation took place.
// Assumes dst_bits is between 1 and DATA_W.
module sat_elem_clamp #(
    parameter int DATA_W = 32,
    parameter int WIDE_W = 2 * DATA_W + 2,
    parameter int BW     = 8
) (
    input  logic signed [WIDE_W-1:0] exact,
    input  logic [BW-1:0]            dst_bits,
    input  logic                     sgn,
    input  logic                     sat_en,
    output logic [DATA_W-1:0]        final_val,
    output logic                     sat_hit
);

    localparam logic [WIDE_W-1:0] ONE = {{(WIDE_W-1){1'b0}}, 1'b1};

    logic [WIDE_W-1:0]        dmask;
    logic signed [WIDE_W-1:0] hi_lim;
    logic signed [WIDE_W-1:0] lo_lim;
    logic                     above;
    logic                     below;
    logic signed [WIDE_W-1:0] picked;
    logic [WIDE_W-1:0]        picked_u;
    logic [BW-1:0]            top_idx;

    // Range limits for the destination width and signedness.
    always_comb begin
        dmask  = (ONE << dst_bits) - ONE;
        hi_lim = sgn ? signed'(dmask >> 1) : signed'(dmask);
        lo_lim = sgn ? signed'(~(dmask >> 1)) : '0;
        above  = exact > hi_lim;
        below  = exact < lo_lim;
    end

    // Pick the clamped or the raw value, then trim it to the destination lane.
    always_comb begin
        if (sat_en && above) begin
            picked = hi_lim;
        end else if (sat_en && below) begin
            picked = lo_lim;
        end else begin
            picked = exact;
        end
        picked_u  = unsigned'(picked) & dmask;
        final_val = picked_u[DATA_W-1:0];
        sat_hit   = sat_en && (above || below);
        top_idx   = dst_bits - BW'(1);
    end

    // R3: an unsigned clamp of a negative exact value lands on zero.
    always_comb begin
        if (sat_en && !sgn && (exact < 0)) begin
            a_r3_unsigned_floor: assert (final_val == '0);
        end
    end

    // R4: a signed clamp keeps the sign of the exact value.
    always_comb begin
        if (sat_en && sgn && (exact < 0)) begin
            a_r4_signed_sign_kept: assert (picked_u[top_idx] == 1'b1);
        end
    end

endmodule

// File: rtl/sat_elem_flags.sv
`timescale 1ns/1ps
// Condition former: compares the destination-width result with zero and
// packs {lt, gt, eq, ov} where ov is the saturation or carry indication.
// Assumes value is zero above dst_bits.
module sat_elem_flags #(
    parameter int DATA_W = 32,
    parameter int BW     = 8
) (
    input  logic [DATA_W-1:0] value,
    input  logic [BW-1:0]     dst_bits,
    input  logic              sgn,
    input  logic              ov_in,
    input  logic              en,
    output logic [3:0]        cond
);

    logic [BW-1:0] top_idx;
    logic          neg;
    logic          is_zero;

    // Derive the three zero-relation bits and gate the field with the enable.
    always_comb begin
        top_idx = dst_bits - BW'(1);
        neg     = sgn && value[top_idx[$clog2(DATA_W)-1:0]];
        is_zero = (value == '0);
        if (en) begin
            cond = {neg, !neg && !is_zero, is_zero, ov_in};
        end else begin
            cond = 4'b0000;
        end
    end

    // R7: exactly one zero relation holds when the field is enabled.
    always_comb begin
        if (en) begin
            a_r7_one_relation: assert ($countones(cond[3:1]) == 1);
        end
    end

    // R7: an unsigned comparison never reports less-than.
    always_comb begin
        if (!sgn) begin
            a_r7_unsigned_no_lt: assert (cond[3] == 1'b0);
        end
    end

endmodule

// File: rtl/sat_elem_alu.sv
`timescale 1ns/1ps
// Saturating vector element ALU, one element per clock. Extends both
// operands from the source width, computes exactly, clamps or wraps into
// the destination width and forms a per-element condition field.
// Illegal combinations are flagged and leave result and cond unchanged.
// Assumes a synchronous active-low reset and one register stage.
module sat_elem_alu
    import sat_elem_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        src_w,
    input  logic [1:0]        dst_w,
    input  logic [1:0]        op_sel,
    input  logic              sgn_n,
    input  logic              sat_en,
    input  logic              cond_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        cond,
    output logic              illegal
);

    localparam int WIDE_W = 2 * DATA_W + 2;
    localparam int MIN_W  = DATA_W / 4;
    localparam int BW     = $clog2(WIDE_W) + 1;
    localparam int N_OPND = 2;

    op_e                      op;
    logic [BW-1:0]            src_bits;
    logic [BW-1:0]            dst_bits;
    logic                     bad_combo;
    logic                     is_carry_op;
    logic [DATA_W-1:0]        raw_opnd [N_OPND];
    logic signed [WIDE_W-1:0] ext_opnd [N_OPND];
    logic signed [WIDE_W-1:0] exact;
    logic                     carry;
    logic [DATA_W-1:0]        final_val;
    logic                     sat_hit;
    logic [3:0]               cond_next;

    // Decode widths, operation and the illegal combinations.
    always_comb begin
        op          = op_e'(op_sel);
        src_bits    = BW'(lane_bits(src_w, MIN_W, DATA_W));
        dst_bits    = BW'(lane_bits(dst_w, MIN_W, DATA_W));
        is_carry_op = (op == OP_ADDC);
        bad_combo   = (src_w == W_RESERVED) || (dst_w == W_RESERVED) ||
                      (sat_en && is_carry_op);
        raw_opnd[0] = op_a;
        raw_opnd[1] = op_b;
    end

    // One extender per operand.
    for (genvar g = 0; g < N_OPND; g++) begin : g_ext
        sat_elem_ext #(
            .DATA_W(DATA_W),
            .WIDE_W(WIDE_W),
            .BW    (BW)
        ) u_ext (
            .raw   (raw_opnd[g]),
            .lane_w(src_bits),
            .sgn   (sgn_n),
            .wide  (ext_opnd[g])
        );
    end

    sat_elem_arith #(
        .DATA_W(DATA_W),
        .WIDE_W(WIDE_W),
        .BW    (BW)
    ) u_arith (
        .opa     (ext_opnd[0]),
        .opb     (ext_opnd[1]),
        .op      (op),
        .dst_bits(dst_bits),
        .exact   (exact),
        .carry   (carry)
    );

    sat_elem_clamp #(
        .DATA_W(DATA_W),
        .WIDE_W(WIDE_W),
        .BW    (BW)
    ) u_clamp (
        .exact    (exact),
        .dst_bits (dst_bits),
        .sgn      (sgn_n),
        .sat_en   (sat_en && !is_carry_op),
        .final_val(final_val),
        .sat_hit  (sat_hit)
    );

    sat_elem_flags #(
        .DATA_W(DATA_W),
        .BW    (BW)
    ) u_flags (
        .value   (final_val),
        .dst_bits(dst_bits),
        .sgn     (sgn_n),
        .ov_in   (is_carry_op ? carry : sat_hit),
        .en      (cond_en),
        .cond    (cond_next)
    );

    // Output register: strobes follow in_valid, data updates only on legal input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
            cond      <= 4'b0000;
        end else begin
            out_valid <= in_valid && !bad_combo;
            illegal   <= in_valid && bad_combo;
            if (in_valid && !bad_combo) begin
                result <= final_val;
                cond   <= cond_next;
            end
        end
    end

    // R2: an accepted input is answered by exactly one strobe next cycle.
    a_r2_answered: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid != illegal));

    // R2: no input means no strobe and held data next cycle.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal && $stable(result) && $stable(cond)));

    // R10: an illegal report leaves result and cond untouched.
    a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(result) && $stable(cond)));

    // R10: the two strobes never rise together.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && illegal));

endmodule

// File: tb/sat_elem_alu_test.sv
`timescale 1ns/1ps
// Self-checking bench: table of vectors walked by one loop, then directed
// tests for reset, idle hold and illegal combinations.
module sat_elem_alu_test;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  sw;
        logic [1:0]  dw;
        logic [1:0]  op;
        logic        n;
        logic        sat;
        logic        cen;
        logic [31:0] res;
        logic [3:0]  cnd;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t TBL [NVEC] = '{
        // R3: unsigned 8-bit add overflows to 255
        '{32'd200, 32'd100, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_00FF, 4'b0101, 8'd3},
        // R3: unsigned subtract below zero clamps to 0
        '{32'd10, 32'd20, 2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 4'b0011, 8'd3},
        // R4: signed 8-bit add clamps to 127
        '{32'd100, 32'd100, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_007F, 4'b0101, 8'd4},
        // R4: signed subtract clamps to -128
        '{32'h0000_009C, 32'd100, 2'd0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000_0080, 4'b1001, 8'd4},
        // R6: no saturation wraps 300 to 44
        '{32'd200, 32'd100, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_002C, 4'b0100, 8'd6},
        // R5: 16-bit source signed multiply into 8-bit destination
        '{32'hABCD_0100, 32'h0000_FFFF, 2'd1, 2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_0080, 4'b1001, 8'd5},
        // R5: 8-bit source unsigned multiply into 16-bit destination
        '{32'h1234_56FF, 32'h0000_00FF, 2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_FE01, 4'b0100, 8'd5},
        // R5 and R12: sign-extended 8-bit sources, negative 16-bit result zero above lane
        '{32'h0000_0080, 32'h0000_0080, 2'd0, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_FF00, 4'b1000, 8'd5},
        // R9: carry-out set by 0xF0 + 0x20
        '{32'h0000_00F0, 32'h0000_0020, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 32'h0000_0010, 4'b0101, 8'd9},
        // R9: no carry-out
        '{32'h0000_0010, 32'h0000_0020, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 32'h0000_0030, 4'b0100, 8'd9},
        // R11: saturating element with cond disabled
        '{32'd200, 32'd100, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_00FF, 4'b0000, 8'd11},
        // R4: signed 32-bit add clamps to maximum
        '{32'h7FFF_FFFF, 32'd1, 2'd2, 2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 32'h7FFF_FFFF, 4'b0101, 8'd4},
        // R3: unsigned 32-bit multiply clamps to maximum
        '{32'hFFFF_FFFF, 32'd2, 2'd2, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'b0101, 8'd3},
        // R8: element after a saturation reports no overflow
        '{32'd1, 32'd2, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_0003, 4'b0100, 8'd8},
        // R7: equal result
        '{32'd5, 32'd5, 2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 4'b0010, 8'd7},
        // R7 and R12: signed 16-bit negative result
        '{32'd3, 32'd5, 2'd1, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0000_FFFE, 4'b1000, 8'd7}
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [1:0]  src_w;
    logic [1:0]  dst_w;
    logic [1:0]  op_sel;
    logic        sgn_n;
    logic        sat_en;
    logic        cond_en;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  cond;
    logic        illegal;

    int checks;
    int errors;
    bit done;

    sat_elem_alu #(.DATA_W(32)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .src_w    (src_w),
        .dst_w    (dst_w),
        .op_sel   (op_sel),
        .sgn_n    (sgn_n),
        .sat_en   (sat_en),
        .cond_en  (cond_en),
        .out_valid(out_valid),
        .result   (result),
        .cond     (cond),
        .illegal  (illegal)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one element on a falling edge.
    task automatic drive(input vec_t v);
        op_a     = v.a;
        op_b     = v.b;
        src_w    = v.sw;
        dst_w    = v.dw;
        op_sel   = v.op;
        sgn_n    = v.n;
        sat_en   = v.sat;
        cond_en  = v.cen;
        in_valid = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep_res;
        logic [3:0]  keep_cnd;
        vec_t        v;
        checks   = 0;
        errors   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        op_a     = 32'd200;
        op_b     = 32'd100;
        src_w    = 2'd0;
        dst_w    = 2'd0;
        op_sel   = 2'd0;
        sgn_n    = 1'b0;
        sat_en   = 1'b1;
        cond_en  = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state even with in_valid held high
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "illegal", {31'd0, illegal}, 32'd0);
        chk("R1", "result", result, 32'd0);
        chk("R1", "cond", {28'd0, cond}, 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // Table walk: each result due one edge after its input.
        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d result", i), result, TBL[i].res);
            chk($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d cond", i), {28'd0, cond}, {28'd0, TBL[i].cnd});
            chk("R2", $sformatf("vec %0d out_valid", i), {31'd0, out_valid}, 32'd1);
        end

        // R2: idle cycle drops the strobe and holds the data
        keep_res = result;
        keep_cnd = cond;
        @(negedge clk);
        chk("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2", "idle illegal", {31'd0, illegal}, 32'd0);
        chk("R2", "idle result hold", result, keep_res);

        // R10: saturation on the carry operation is illegal
        v = '{32'h0000_00F0, 32'h0000_0020, 2'd0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 32'd0, 4'd0, 8'd10};
        drive(v);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "sat+carry illegal", {31'd0, illegal}, 32'd1);
        chk("R10", "sat+carry out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10", "sat+carry result hold", result, keep_res);
        chk("R10", "sat+carry cond hold", {28'd0, cond}, {28'd0, keep_cnd});

        // R10: reserved destination width code is illegal
        v = '{32'd1, 32'd1, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 32'd0, 4'd0, 8'd10};
        drive(v);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "dst code 3 illegal", {31'd0, illegal}, 32'd1);
        chk("R10", "dst code 3 result hold", result, keep_res);

        // R10: reserved source width code is illegal
        v = '{32'd1, 32'd1, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'd0, 4'd0, 8'd10};
        drive(v);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "src code 3 illegal", {31'd0, illegal}, 32'd1);
        chk("R10", "src code 3 out_valid", {31'd0, out_valid}, 32'd0);

        // R6: a legal element right after the illegal ones writes again
        v = '{32'd250, 32'd10, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'd0, 4'd0, 8'd6};
        drive(v);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6", "wrap after illegal", result, 32'h0000_0004);
        chk("R11", "cond disabled", {28'd0, cond}, 32'd0);
        chk("R10", "illegal cleared", {31'd0, illegal}, 32'd0);

        // R1: mid-run reset clears a pending element
        v = TBL[0];
        drive(v);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "mid reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "mid reset result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule